// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns the system clock into CAN bit timing. A programmable prescaler divides the clock into time quanta. Each nominal bit is built from three parts: a synchronisation segment of one quantum, a first phase segment, and a second phase segment. The block pulses a sample strobe, which carries the received bit, at the boundary between the two phase segments. It pulses a transmit-point strobe when the second segment ends, which is where the next bit begins.

The unit keeps its timing aligned with the receive line. A dominant edge that arrives while the bus is idle is taken as start-of-frame. It restarts the prescaler and the bit, and the quantum that follows becomes the sync segment. Once a frame is running, an edge that falls inside a phase segment moves the sample point by the phase error, limited to the jump width. A late edge, in the first segment, lengthens that segment. An early edge, in the second segment, shortens it. The edge-select input sets which edges count: only recessive-to-dominant edges, or both directions.

The frame logic drives the bus-idle and transmitting-dominant indications. The bit-stream logic consumes the strobes.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts cfgPrescale+1 system clocks. tqStrobe is a one-cycle pulse, one per quantum, and every sample strobe coincides with a tqStrobe pulse.
- R2: When no edge is seen, a bit is 1 + (cfgSeg1+1) + (cfgSeg2+1) quanta long. sampleStrobe pulses at the end of the first phase segment, and txPointStrobe pulses at the end of the second. The two strobes are never high together.
- R3: sampleBit holds the value of rxBit at the clock edge that ends the first phase segment. It keeps that value until the next sample.
- R4: A 1-to-0 change of rxBit while busIdle=1 forces a hard sync, whatever cfgBothEdges and txDominant are. The prescaler restarts, the next quantum is the sync segment, and the first sample strobe follows the edge after (cfgPrescale+1)*(cfgSeg1+2) clocks. The restarted bit gives no transmit-point pulse.
- R5: An edge seen during quantum k (counted from 1) of the first phase segment lengthens that segment by min(k, cfgJump+1) quanta.
- R6: An edge seen during quantum j (counted from 1) of the second phase segment shortens that segment by min((cfgSeg2+1)-j, cfgJump+1) quanta.
- R7: With cfgBothEdges=0, only 1-to-0 changes of rxBit resynchronise, and 0-to-1 changes have no effect on the timing. With cfgBothEdges=1, both directions resynchronise.
- R8: While txDominant=1, no resynchronisation takes place.
- R9: At most one resynchronisation happens between two sample strobes. After a hard sync, none happens before the first sample strobe.
- R10: During reset, tqStrobe, sampleStrobe and txPointStrobe are 0 and sampleBit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBit | input | 1 | Receive line, 1 = recessive |
| busIdle | input | 1 | Bus is idle; a dominant edge here is start-of-frame |
| txDominant | input | 1 | This node is driving a dominant bit |
| cfgPrescale | input | 6 | Quantum length minus one, in system clocks |
| cfgJump | input | 2 | Jump width minus one, in quanta |
| cfgSeg1 | input | 4 | First phase segment length minus one, in quanta |
| cfgSeg2 | input | 3 | Second phase segment length minus one, in quanta |
| cfgBothEdges | input | 1 | 0: falling edges only, 1: both edges resynchronise |
| tqStrobe | output | 1 | One pulse per time quantum |
| sampleStrobe | output | 1 | Sample point pulse |
| sampleBit | output | 1 | Bit captured at the last sample point |
| txPointStrobe | output | 1 | Bit boundary pulse where the next bit may be driven |

## Verification
Every strobe is registered. Each one is high for the single clock after the rising edge that closes the quantum it marks, so a result lands exactly (cfgPrescale+1) times a whole number of quanta after the clock edge that captured the stimulus edge. The bench counts rising edges and changes rxBit shortly after a rising edge, so a change seen at edge E belongs to a known quantum. It reads the strobes on the falling edge and compares the edge count at which each strobe appears with the figure worked out from the segment lengths and the clamped phase error.

// File: rtl/can_btu_pkg.sv
package can_btu_pkg;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } btuPhase_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic hardSync;
    logic sampleNow;
    logic txNow;
  } btuStrobe_t;

endpackage

// File: rtl/can_btu_datapath.sv
module can_btu_datapath
  import can_btu_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  btuStrobe_t       ctl,
  output logic             tqTick,
  output logic             fallEdge,
  output logic             riseEdge,
  output logic             tqStrobe,
  output logic             sampleStrobe,
  output logic             sampleBit,
  output logic             txPointStrobe
);

  logic [PRE_W-1:0] preCnt;
  logic             rxPrev;

  assign tqTick   = (preCnt >= cfgPrescale);
  assign fallEdge = rxPrev & ~rxBit;
  assign riseEdge = ~rxPrev & rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      rxPrev <= 1'b1;
    end else begin
      rxPrev <= rxBit;
      if (ctl.hardSync || tqTick) preCnt <= '0;
      else                        preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tqStrobe      <= 1'b0;
      sampleStrobe  <= 1'b0;
      sampleBit     <= 1'b1;
      txPointStrobe <= 1'b0;
    end else begin
      tqStrobe      <= tqTick & ~ctl.hardSync;
      sampleStrobe  <= ctl.sampleNow;
      txPointStrobe <= ctl.txNow;
      if (ctl.sampleNow) sampleBit <= rxBit;
    end
  end

  // R4
  hard_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hardSync |=> (preCnt == '0));

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStrobe && txPointStrobe));

  // R1
  sample_on_quantum_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> tqStrobe);

endmodule

// File: rtl/can_btu_ctrl.sv
module can_btu_ctrl
  import can_btu_pkg::*;
#(
  parameter int SJW_W  = 2,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tqTick,
  input  logic              fallEdge,
  input  logic              riseEdge,
  input  logic              busIdle,
  input  logic              txDominant,
  input  logic              cfgBothEdges,
  input  logic [SJW_W-1:0]  cfgJump,
  input  logic [SEG1_W-1:0] cfgSeg1,
  input  logic [SEG2_W-1:0] cfgSeg2,
  output btuStrobe_t        ctl
);

  localparam int MAX12 = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
  localparam int MAXW  = (MAX12 > SJW_W) ? MAX12 : SJW_W;
  localparam int CNT_W = MAXW + 1;

  btuPhase_e        phase;
  logic [CNT_W-1:0] qIdx, segEnd, segEndNext;
  logic [CNT_W-1:0] sjwLen, lateErr, lateStep, earlyErr, earlyStep;
  logic             resyncOk, edgeSel, hardSync, resyncNow, lastQ;

  assign hardSync  = busIdle & fallEdge;
  assign edgeSel   = fallEdge | (cfgBothEdges & riseEdge);
  assign resyncNow = edgeSel & ~busIdle & ~txDominant & resyncOk & (phase != PH_SYNC);

  // phase error in quanta, clamped to the jump width
  assign sjwLen    = CNT_W'(cfgJump) + CNT_W'(1);
  assign lateErr   = qIdx + CNT_W'(1);
  assign lateStep  = (lateErr < sjwLen) ? lateErr : sjwLen;
  assign earlyErr  = segEnd - qIdx;
  assign earlyStep = (earlyErr < sjwLen) ? earlyErr : sjwLen;

  always_comb begin
    segEndNext = segEnd;
    if (resyncNow) begin
      if (phase == PH_SEG1) segEndNext = segEnd + lateStep;
      else                  segEndNext = segEnd - earlyStep;
    end
  end

  assign lastQ         = (qIdx >= segEndNext);
  assign ctl.hardSync  = hardSync;
  assign ctl.sampleNow = tqTick & (phase == PH_SEG1) & lastQ & ~hardSync;
  assign ctl.txNow     = tqTick & (phase == PH_SEG2) & lastQ & ~hardSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_SYNC;
      qIdx     <= '0;
      segEnd   <= '0;
      resyncOk <= 1'b0;
    end else if (hardSync) begin
      phase    <= PH_SYNC;
      qIdx     <= '0;
      segEnd   <= '0;
      resyncOk <= 1'b0;
    end else begin
      segEnd <= segEndNext;
      if (resyncNow) resyncOk <= 1'b0;
      if (tqTick) begin
        case (phase)
          PH_SYNC: begin
            phase  <= PH_SEG1;
            qIdx   <= '0;
            segEnd <= CNT_W'(cfgSeg1);
          end
          PH_SEG1: begin
            if (lastQ) begin
              phase    <= PH_SEG2;
              qIdx     <= '0;
              segEnd   <= CNT_W'(cfgSeg2);
              resyncOk <= 1'b1;
            end else begin
              qIdx <= qIdx + CNT_W'(1);
            end
          end
          PH_SEG2: begin
            if (lastQ) begin
              phase  <= PH_SYNC;
              qIdx   <= '0;
              segEnd <= '0;
            end else begin
              qIdx <= qIdx + CNT_W'(1);
            end
          end
          default: begin
            phase <= PH_SYNC;
            qIdx  <= '0;
          end
        endcase
      end
    end
  end

  // R2
  sync_one_quantum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SYNC && tqTick && !hardSync) |=> (phase == PH_SEG1 && qIdx == '0));

  // R4
  hard_sync_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    hardSync |=> (phase == PH_SYNC && qIdx == '0));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDominant && !hardSync && !tqTick) |=> $stable(segEnd));

  // R6
  qidx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_SYNC) |-> (qIdx <= segEnd));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_btu_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int SJW_W  = 2,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxBit,
  input  logic              busIdle,
  input  logic              txDominant,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [SJW_W-1:0]  cfgJump,
  input  logic [SEG1_W-1:0] cfgSeg1,
  input  logic [SEG2_W-1:0] cfgSeg2,
  input  logic              cfgBothEdges,
  output logic              tqStrobe,
  output logic              sampleStrobe,
  output logic              sampleBit,
  output logic              txPointStrobe
);

  btuStrobe_t ctl;
  logic       tqTick, fallEdge, riseEdge;

  can_btu_datapath #(.PRE_W(PRE_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .rxBit        (rxBit),
    .cfgPrescale  (cfgPrescale),
    .ctl          (ctl),
    .tqTick       (tqTick),
    .fallEdge     (fallEdge),
    .riseEdge     (riseEdge),
    .tqStrobe     (tqStrobe),
    .sampleStrobe (sampleStrobe),
    .sampleBit    (sampleBit),
    .txPointStrobe(txPointStrobe)
  );

  can_btu_ctrl #(.SJW_W(SJW_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tqTick      (tqTick),
    .fallEdge    (fallEdge),
    .riseEdge    (riseEdge),
    .busIdle     (busIdle),
    .txDominant  (txDominant),
    .cfgBothEdges(cfgBothEdges),
    .cfgJump     (cfgJump),
    .cfgSeg1     (cfgSeg1),
    .cfgSeg2     (cfgSeg2),
    .ctl         (ctl)
  );

endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;

  logic       clk = 1'b0;
  logic       rstN, rxBit, busIdle, txDominant, cfgBothEdges;
  logic [5:0] cfgPrescale;
  logic [1:0] cfgJump;
  logic [3:0] cfgSeg1;
  logic [2:0] cfgSeg2;
  logic       tqStrobe, sampleStrobe, sampleBit, txPointStrobe;

  always #10 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .busIdle(busIdle), .txDominant(txDominant),
    .cfgPrescale(cfgPrescale), .cfgJump(cfgJump), .cfgSeg1(cfgSeg1), .cfgSeg2(cfgSeg2),
    .cfgBothEdges(cfgBothEdges), .tqStrobe(tqStrobe), .sampleStrobe(sampleStrobe),
    .sampleBit(sampleBit), .txPointStrobe(txPointStrobe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit done = 0;

  // monitor: records strobe cycles at the falling edge
  int   tStart = 32'h7fffffff;
  int   nS, nT, tqMid, firstTq;
  int   sCyc [2];
  int   tCyc [2];
  logic sBit [2];

  always @(negedge clk) begin
    if (cyc >= tStart) begin
      if (tqStrobe) begin
        if (firstTq < 0) firstTq = cyc;
        if (nS == 1) tqMid++;
      end
      if (sampleStrobe) begin
        if (nS < 2) begin sCyc[nS] = cyc; sBit[nS] = sampleBit; end
        nS++;
      end
      if (txPointStrobe) begin
        if (nT < 2) tCyc[nT] = cyc;
        nT++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(int c);
    while (cyc < c) begin @(posedge clk); #2; end
  endtask

  // variant: 0 late edge in seg1, 1 early rising edge both-edges, 2 rising ignored,
  // 3 edge while transmitting dominant, 4 second edge in the same interval
  task automatic runTrial(int p, int s1, int s2, int jw, int variant, int kRaw, int rRaw);
    int q, l1, l2, jl, t, s0, b1, k, r, e, sh, expTx, expS1, expBit;
    string req;
    q = p + 1; l1 = s1 + 1; l2 = s2 + 1; jl = jw + 1;
    cfgPrescale = 6'(p); cfgSeg1 = 4'(s1); cfgSeg2 = 3'(s2); cfgJump = 2'(jw);
    cfgBothEdges = (variant == 1 || variant == 4);
    txDominant = (variant == 3);
    busIdle = 1'b1; rxBit = 1'b1;
    t  = cyc + 4;
    s0 = t + q * (l1 + 1);
    b1 = s0 + q * l2;
    r  = 1 + (rRaw % q);
    waitCyc(t - 1);
    nS = 0; nT = 0; tqMid = 0; firstTq = -1;
    sCyc[0] = -1; sCyc[1] = -1; tCyc[0] = -1; tCyc[1] = -1;
    tStart = t;
    rxBit = 1'b0;            // start-of-frame, seen at edge t
    waitCyc(t);
    busIdle = 1'b0;
    case (variant)
      1, 2: begin
        k = 1 + (kRaw % l2);
        e = s0 + (k - 1) * q + r;
        waitCyc(e - 1); rxBit = 1'b1;
        sh = (variant == 1) ? imin(l2 - k, jl) : 0;
        expTx = s0 + q * (l2 - sh);
        expS1 = expTx + q * (l1 + 1);
        expBit = 1;
        req = (variant == 1) ? "R6" : "R7";
      end
      default: begin
        k = 1 + (kRaw % l1);
        e = b1 + k * q + r;
        if (variant == 4) begin waitCyc(b1); rxBit = 1'b1; end
        else begin waitCyc(s0); rxBit = 1'b1; end
        waitCyc(e - 1); rxBit = 1'b0;
        if (variant == 4) begin waitCyc(e); rxBit = 1'b1; end
        expTx = b1;
        expS1 = b1 + q * (l1 + 1) + ((variant == 3) ? 0 : q * imin(k, jl));
        expBit = (variant == 4) ? 1 : 0;
        req = (variant == 0) ? "R5" : (variant == 3) ? "R8" : "R9";
      end
    endcase
    waitCyc(expS1 + 2);
    chkEq("R4", "first sample cycle after hard sync", sCyc[0], s0);
    chkEq("R1", "first quantum strobe after hard sync", firstTq, t + q);
    chkEq("R3", "bit at first sample", int'(sBit[0]), 0);
    chkEq(req, "bit boundary cycle", tCyc[0], expTx);
    chkEq(req, "second sample cycle", sCyc[1], expS1);
    chkEq("R3", "bit at second sample", int'(sBit[1]), expBit);
    chkEq("R1", "quanta between samples", tqMid, (expS1 - s0) / q);
    tStart = 32'h7fffffff;
    rxBit = 1'b1; busIdle = 1'b1; txDominant = 1'b0;
    waitCyc(cyc + 3);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rstN = 1'b0; rxBit = 1'b1; busIdle = 1'b1; txDominant = 1'b0; cfgBothEdges = 1'b0;
    cfgPrescale = 6'd1; cfgJump = 2'd0; cfgSeg1 = 4'd3; cfgSeg2 = 3'd2;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chkEq("R10", "tqStrobe in reset", int'(tqStrobe), 0);
    chkEq("R10", "sampleStrobe in reset", int'(sampleStrobe), 0);
    chkEq("R10", "txPointStrobe in reset", int'(txPointStrobe), 0);
    chkEq("R10", "sampleBit in reset", int'(sampleBit), 1);
    rstN = 1'b1;
    waitCyc(cyc + 5);

    // directed corners: largest prescale with clamped late edge, minimum lengths
    runTrial(63, 15, 7, 3, 0, 15, 63);
    runTrial(0, 0, 0, 0, 1, 0, 0);
    runTrial(2, 3, 7, 1, 1, 0, 2);
    runTrial(1, 5, 3, 3, 0, 1, 0);
    runTrial(3, 2, 4, 2, 2, 1, 1);
    runTrial(1, 6, 2, 1, 3, 3, 1);
    runTrial(2, 7, 5, 3, 4, 2, 0);

    for (int i = 0; i < 40; i++) begin
      runTrial($urandom % 4, $urandom % 16, $urandom % 8, $urandom % 4,
               $urandom % 5, $urandom % 64, $urandom % 64);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule